// File: doc/BRIEF.md
# Framed Serial Byte Receiver

This block receives bytes from a write-only three-wire serial link: an active-low frame enable, a serial clock and a data line, plus a select line that marks each byte as a command or as display data. The link has no return path. The serial lines are sampled by a faster system clock. A rising serial-clock edge is found by comparing two successive synchronized samples.

Eight bits are shifted in, most significant bit first. The select line is captured together with the eighth bit. The block then raises a strobe for one system-clock cycle, together with the assembled byte and a data/command flag. The byte and the flag hold their values until the next strobe.

Raising the frame enable, or applying the active-low reset, clears the bit count at once. A partly received byte is then dropped. While the enable stays low, bytes may follow each other with no gap.

Top module: `serial_byte_rx`

## Requirements
- R1: A bit is taken only on a rising edge of the serial clock. Changes on the data line while the serial clock is low or high have no effect.
- R2: The first bit of a byte lands in bit 7 of `rx_byte` and the eighth bit lands in bit 0.
- R3: The select line is read together with the eighth bit of a byte. A value of 0 gives `rx_is_data`=0 (command) and a value of 1 gives `rx_is_data`=1 (display data). Its level during bits one to seven is ignored.
- R4: Each complete byte gives exactly one `rx_valid` pulse, one system-clock cycle long. `rx_byte` and `rx_is_data` change only in a cycle where `rx_valid` is high.
- R5: While `ser_en_n` is high, serial-clock pulses are ignored and no strobe is produced.
- R6: When `ser_en_n` goes high part way through a byte, the partial byte is dropped. After the next falling edge of the enable, the first rising serial-clock edge is taken as bit 7.
- R7: While `ser_en_n` stays low after an eighth bit, the next rising serial-clock edge is taken as bit 7 of a new byte.
- R8: A low `rst_n` drops a byte in progress. If the enable is low when reset is released, the next rising serial-clock edge is taken as bit 7.
- R9: After reset, `rx_valid`, `rx_byte` and `rx_is_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en_n | input | 1 | Frame enable, active low, asynchronous to clk |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_dat | input | 1 | Serial data, sampled on the serial clock's rising edge |
| ser_dc | input | 1 | Select line: 0 for command, 1 for display data |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| rx_byte | output | 8 | Received byte, first bit in the MSB |
| rx_is_data | output | 1 | 1 when the byte is display data, 0 when it is a command |

## Verification
Some properties can be checked on every cycle. The assertions check that a detected serial-clock rise is never followed at once by another. They check that the strobe lasts a single cycle and always follows an accepted bit. They also check that an idle enable or a reset clears the bit count and the strobe, and that the byte outputs stay still between strobes.

Other behaviour can only be shown by the bench's scenarios. These cover bit order, reading the select line on the eighth bit only, and back-to-back bytes within one frame. They also cover dropping a partial byte when the enable is raised or reset is applied, and restarting cleanly at bit 7 afterwards.

// File: rtl/serial_byte_rx_pkg.sv
// Package: shared defaults and the byte-kind encoding for the serial byte receiver.
// Assumes: consumers use these values as parameter defaults.
package serial_byte_rx_pkg;
    parameter int unsigned DEF_BYTE_W      = 8;
    parameter int unsigned DEF_SYNC_STAGES = 2;

    // Kind of a received byte, taken from the select line on the last bit.
    typedef enum logic {
        KIND_CMD  = 1'b0,
        KIND_DATA = 1'b1
    } rx_kind_e;
endpackage

// File: rtl/serial_byte_rx_sync.sv
// Multi-bit flop-chain synchronizer for asynchronous serial lines.
// Assumes: each bit is an independent level that is stable for several clk
// cycles around any edge that matters. STAGES must be at least 2.
module serial_byte_rx_sync #(
    parameter int unsigned        WIDTH     = 4,
    parameter int unsigned        STAGES    = 2,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw asynchronous lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RESET_VAL;
                    else        chain[g] <= async_in;
                end
            end else begin : g_next
                // Later stages: let metastability resolve.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RESET_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/serial_byte_rx_edge.sv
// Finds rising edges of the synchronized serial clock and gates them with the
// synchronized frame enable.
// Assumes: the inputs are already synchronized to clk.
module serial_byte_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic en_n_s,
    output logic bit_tick,
    output logic idle
);
    logic sclk_prev;

    // Keep the previous serial-clock sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    logic sclk_rise;
    assign sclk_rise = sclk_s & ~sclk_prev;
    assign idle      = en_n_s;
    assign bit_tick  = sclk_rise & ~en_n_s;

    AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !sclk_rise); // R1
endmodule

// File: rtl/serial_byte_rx_shift.sv
// Bit counter and shift register. It assembles a byte MSB first and raises a
// one-cycle strobe with the byte and its kind on the last bit.
// Assumes: bit_tick is at most one cycle wide per serial bit, and W >= 3.
module serial_byte_rx_shift
    import serial_byte_rx_pkg::*;
#(
    parameter int unsigned W = DEF_BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_tick,
    input  logic         idle,
    input  logic         bit_in,
    input  logic         dc_in,
    output logic         valid,
    output logic [W-1:0] payload,
    output rx_kind_e     kind
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;
    logic [W-2:0]  shreg;

    // Count bits, shift data in, and publish the byte on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            shreg   <= '0;
            valid   <= 1'b0;
            payload <= '0;
            kind    <= KIND_CMD;
        end else begin
            valid <= 1'b0;
            if (idle) begin
                cnt <= '0;
            end else if (bit_tick) begin
                shreg <= {shreg[W-3:0], bit_in};
                if (cnt == LAST) begin
                    cnt     <= '0;
                    valid   <= 1'b1;
                    payload <= {shreg, bit_in};
                    kind    <= dc_in ? KIND_DATA : KIND_CMD;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R4
    AST_STROBE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(bit_tick)); // R4
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> (cnt == '0) && !valid); // R5
    AST_RESET_ABORTS: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0) && !valid); // R8
endmodule

// File: rtl/serial_byte_rx.sv
// Top level of the framed serial byte receiver. It synchronizes the four
// serial lines, detects bit edges, and assembles bytes.
// Assumes: clk is fast enough that every serial-clock phase lasts at least
// SYNC_STAGES+2 clk cycles, and data/select are stable around the rising edge.
module serial_byte_rx
    import serial_byte_rx_pkg::*;
#(
    parameter int unsigned BYTE_W      = DEF_BYTE_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_dc,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_is_data
);
    localparam int unsigned LINES = 4;
    localparam logic [LINES-1:0] LINE_RST = 4'b1000;

    logic [LINES-1:0] lines_s;
    logic             bit_tick;
    logic             idle;
    rx_kind_e         kind;

    serial_byte_rx_sync #(
        .WIDTH     (LINES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (LINE_RST)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_en_n, ser_clk, ser_dat, ser_dc}),
        .sync_out (lines_s)
    );

    serial_byte_rx_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (lines_s[2]),
        .en_n_s   (lines_s[3]),
        .bit_tick (bit_tick),
        .idle     (idle)
    );

    serial_byte_rx_shift #(
        .W (BYTE_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .idle     (idle),
        .bit_in   (lines_s[1]),
        .dc_in    (lines_s[0]),
        .valid    (rx_valid),
        .payload  (rx_byte),
        .kind     (kind)
    );

    assign rx_is_data = (kind == KIND_DATA);

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte) && $stable(rx_is_data)); // R4
endmodule

// File: tb/serial_byte_rx_test.sv
module serial_byte_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_en_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_dc = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       rx_is_data;

    int errors = 0;
    int checks = 0;
    int n_strobe = 0;
    int n_long = 0;
    logic [7:0] last_byte = '0;
    logic       last_flag = 1'b0;
    logic       prev_valid = 1'b0;

    always #2.5 clk = ~clk;

    serial_byte_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_dc(ser_dc), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_is_data(rx_is_data)
    );

    // Record strobes away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            n_strobe  <= n_strobe + 1;
            last_byte <= rx_byte;
            last_flag <= rx_is_data;
            if (prev_valid) n_long <= n_long + 1;
        end
        prev_valid <= rx_valid;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit; data and select change while the serial clock is low.
    task automatic send_bit(input logic b, input logic dc);
        ser_dat = b;
        ser_dc  = dc;
        wait_clk(3);
        ser_dat = b;
        wait_clk(3);
        ser_clk = 1'b1;
        wait_clk(6);
        ser_clk = 1'b0;
    endtask

    // Full byte; the select line is wrong on bits 1..7 and correct on bit 8.
    task automatic send_byte(input logic [7:0] b, input logic dc);
        for (int i = 7; i >= 0; i--) send_bit(b[i], (i == 0) ? dc : ~dc);
        wait_clk(6);
    endtask

    localparam int NVEC = 6;
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b1, 8'h80},
        {1'b0, 8'h01}, {1'b1, 8'hFF}, {1'b0, 8'h00}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check("R9 valid", int'(rx_valid), 0);
        check("R9 byte", int'(rx_byte), 0);
        check("R9 flag", int'(rx_is_data), 0);

        // Table: all bytes in one frame, back to back (R1, R2, R3, R7).
        ser_en_n = 1'b0;
        wait_clk(6);
        base = n_strobe;
        for (int k = 0; k < NVEC; k++) begin
            send_byte(VEC[k][7:0], VEC[k][8]);
            check("R2 byte", int'(last_byte), int'(VEC[k][7:0]));
            check("R3 flag", int'(last_flag), int'(VEC[k][8]));
            check("R7 strobe count", n_strobe - base, k + 1);
        end
        check("R4 single-cycle strobes", n_long, 0);

        // R5: pulses with the enable high are ignored.
        ser_en_n = 1'b1;
        wait_clk(6);
        base = n_strobe;
        send_byte(8'h5A, 1'b1);
        send_byte(8'hC3, 1'b0);
        check("R5 no strobe while idle", n_strobe - base, 0);
        check("R5 byte held", int'(last_byte), 8'h00);

        // R6: partial byte dropped when the enable rises.
        ser_en_n = 1'b0;
        wait_clk(6);
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b1);
        ser_en_n = 1'b1;
        wait_clk(8);
        ser_en_n = 1'b0;
        wait_clk(6);
        base = n_strobe;
        send_byte(8'h96, 1'b1);
        check("R6 one strobe", n_strobe - base, 1);
        check("R6 byte from bit 7", int'(last_byte), 8'h96);
        check("R6 flag", int'(last_flag), 1);

        // R8: reset aborts a byte; the enable stays low throughout.
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
        check("R8 byte cleared", int'(rx_byte), 0);
        wait_clk(6);
        base = n_strobe;
        send_byte(8'hE1, 1'b0);
        check("R8 one strobe", n_strobe - base, 1);
        check("R8 byte from bit 7", int'(last_byte), 8'hE1);
        check("R8 flag", int'(last_flag), 0);
        check("R4 single-cycle strobes final", n_long, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule